// File: doc/BRIEF.md
# Transfer Stream Pointer and Count Sequencer

This block is the bookkeeping core of one channel of a direct memory access engine. It holds the current peripheral address, the current memory address and the number of items still to move. On every completed data transfer it advances each pointer by its width-dependent step and takes one off the count. The bus logic and the data buffer sit elsewhere and only report, through a strobe, that one item has gone through.

Software programs direction, the two element widths, the increment and burst options, the start addresses and an item count, then raises the enable bit. The sequencer checks the settings and either refuses the start with an error flag or begins counting. It stops when the count runs out, when enable is dropped, or, under peripheral flow control, when the peripheral signals the last item. In circular or two-buffer operation it rewinds itself instead of stopping; with two buffers it also alternates between two memory base addresses, so software can use the idle buffer. Half-way, completion and error flags are merged into one interrupt line.

Top module: `sseq_top`

## Requirements
- R1: A valid start loads `remaining` with `cfg_count` (allowed range 1 to 65535). Each `xfer_done` pulse while running lowers it by exactly one, and it is never zero while `active` is high.
- R2: With its increment bit set, a pointer advances after each transfer by 1, 2 or 4 for width codes 0 (byte), 1 (half-word) and 2 (word). With the bit clear, the pointer does not move.
- R3: When `cfg_pfix` and `cfg_pinc` are both set, the peripheral pointer advances by 4 whatever its width. The memory pointer step does not depend on `cfg_pfix`.
- R4: Without circular or two-buffer operation, the transfer that brings the count to zero clears `active` and sets `evt_done`.
- R5: Clearing `cfg_en` while running clears `active` on the next edge without setting `evt_done`. A new start needs a fresh 0-to-1 edge of `cfg_en` and reloads count and pointers.
- R6: With `cfg_pflow` set, `periph_eot` while running stops the stream and sets `evt_done`. If `xfer_done` comes in the same cycle, that transfer is counted and stepped first. With `cfg_pflow` clear, `periph_eot` has no effect.
- R7: In circular operation (`cfg_circ`), reaching zero sets `evt_done`, reloads the count and both pointers from their start values, and the stream keeps running.
- R8: In two-buffer operation (`cfg_dbuf`), each time the count reaches zero `buf_sel` toggles and the memory pointer restarts at `cfg_m1addr` when `buf_sel` becomes 1, or at `cfg_m0addr` when it becomes 0. A start always begins with `buf_sel` = 0.
- R9: `evt_half` is set by the transfer that brings `remaining` to the programmed count divided by two, rounded down.
- R10: A start is refused (`evt_err` set, `active` stays low) when a width code is 3, direction code is 3, the count is 0, a half-word address has bit 0 set, a word address has bits 1:0 non-zero (`cfg_m1addr` only checked with `cfg_dbuf`), a burst is requested on a side whose increment is off, or circular or two-buffer operation is requested with direction code 2 (memory-to-memory). Direction codes: 0 peripheral-to-memory, 1 memory-to-peripheral, 2 memory-to-memory.
- R11: The event flags stay set until the next start attempt, which clears `evt_half` and `evt_done` and sets `evt_err` to the outcome of its check. `irq` is high exactly when any of the three flags is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Stream enable; rising edge starts |
| cfg_dir | input | 2 | Direction code |
| cfg_psize | input | 2 | Peripheral width code |
| cfg_msize | input | 2 | Memory width code |
| cfg_pinc | input | 1 | Peripheral pointer increment |
| cfg_minc | input | 1 | Memory pointer increment |
| cfg_pfix | input | 1 | Force peripheral step of 4 |
| cfg_pburst | input | 1 | Burst requested on peripheral side |
| cfg_mburst | input | 1 | Burst requested on memory side |
| cfg_circ | input | 1 | Circular operation |
| cfg_dbuf | input | 1 | Two-buffer operation |
| cfg_pflow | input | 1 | Peripheral decides end of transfer |
| cfg_paddr | input | AW | Peripheral start address |
| cfg_m0addr | input | AW | Memory buffer 0 start address |
| cfg_m1addr | input | AW | Memory buffer 1 start address |
| cfg_count | input | CW | Programmed item count |
| xfer_done | input | 1 | One item has been transferred |
| periph_eot | input | 1 | Peripheral end-of-transfer signal |
| cur_paddr | output | AW | Current peripheral address |
| cur_maddr | output | AW | Current memory address |
| remaining | output | CW | Items still to transfer |
| active | output | 1 | Stream running |
| buf_sel | output | 1 | Memory buffer in use |
| evt_half | output | 1 | Half-way flag |
| evt_done | output | 1 | Completion flag |
| evt_err | output | 1 | Configuration error flag |
| irq | output | 1 | OR of the three flags |

## Verification
The two functions that can meet in one cycle are the last counted transfer and the peripheral's end-of-transfer signal, and the wrap of a circular or two-buffer stream and a peripheral stop. The bench drives `xfer_done` and `periph_eot` together in a directed case and, at random, on the wrap cycle. It judges them by a bench model that steps first and stops afterwards, checking that the count, the pointers, `buf_sel` and `evt_done` all show the item as moved and that the stream is idle.

// File: rtl/sseq_pkg.sv
`timescale 1ns/1ps
package sseq_pkg;
  typedef enum logic [1:0] {WID_BYTE = 2'd0, WID_HALF = 2'd1, WID_WORD = 2'd2, WID_BAD = 2'd3} wid_e;
  typedef enum logic [1:0] {DIR_P2M = 2'd0, DIR_M2P = 2'd1, DIR_M2M = 2'd2, DIR_BAD = 2'd3} dir_e;

  localparam int unsigned STEP_W = 3;

  function automatic logic [STEP_W-1:0] wid_step(input wid_e w);
    case (w)
      WID_HALF: return 3'd2;
      WID_WORD: return 3'd4;
      default:  return 3'd1;
    endcase
  endfunction

  function automatic logic wid_aligned(input wid_e w, input logic [1:0] lsb);
    case (w)
      WID_HALF: return ~lsb[0];
      WID_WORD: return (lsb == 2'b00);
      default:  return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/sseq_cfg_check.sv
`timescale 1ns/1ps
module sseq_cfg_check
  import sseq_pkg::*;
(
  input  logic [1:0] dir,
  input  logic [1:0] psize,
  input  logic [1:0] msize,
  input  logic       pinc,
  input  logic       minc,
  input  logic       pburst,
  input  logic       mburst,
  input  logic       circ,
  input  logic       dbuf,
  input  logic [1:0] p_lsb,
  input  logic [1:0] m0_lsb,
  input  logic [1:0] m1_lsb,
  input  logic       count_zero,
  output logic       bad
);
  wid_e pw, mw;
  dir_e dw;
  logic code_bad, align_bad, burst_bad, mode_bad;

  always_comb begin
    pw        = wid_e'(psize);
    mw        = wid_e'(msize);
    dw        = dir_e'(dir);
    code_bad  = (pw == WID_BAD) | (mw == WID_BAD) | (dw == DIR_BAD) | count_zero;
    align_bad = ~wid_aligned(pw, p_lsb) | ~wid_aligned(mw, m0_lsb)
              | (dbuf & ~wid_aligned(mw, m1_lsb));
    burst_bad = (pburst & ~pinc) | (mburst & ~minc);
    mode_bad  = (dw == DIR_M2M) & (circ | dbuf);
    bad       = code_bad | align_bad | burst_bad | mode_bad;
  end
endmodule

// File: rtl/sseq_ptr.sv
`timescale 1ns/1ps
module sseq_ptr
  import sseq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              wrap,
  input  logic              swap,
  input  logic              adv,
  input  logic [STEP_W-1:0] step,
  input  logic [AW-1:0]     base0,
  input  logic [AW-1:0]     base1,
  output logic [AW-1:0]     cur,
  output logic              sel
);
  localparam int PAD = AW - STEP_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= '0;
      sel <= 1'b0;
    end else if (load) begin
      cur <= base0;
      sel <= 1'b0;
    end else if (wrap) begin
      if (swap) begin
        sel <= ~sel;
        cur <= sel ? base0 : base1;
      end else begin
        cur <= sel ? base1 : base0;
      end
    end else if (adv) begin
      cur <= cur + {{PAD{1'b0}}, step};
    end
  end
endmodule

// File: rtl/sseq_count.sv
`timescale 1ns/1ps
module sseq_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          reload,
  input  logic          dec,
  input  logic [CW-1:0] prog,
  output logic [CW-1:0] rem,
  output logic          last,
  output logic          half_hit
);
  logic [CW-1:0] prog_q;
  logic [CW-1:0] rem_m1;

  always_comb begin
    rem_m1   = rem - CW'(1);
    last     = (rem == CW'(1));
    half_hit = (rem_m1 == (prog_q >> 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem    <= '0;
      prog_q <= '0;
    end else if (load) begin
      rem    <= prog;
      prog_q <= prog;
    end else if (reload) begin
      rem    <= prog_q;
    end else if (dec) begin
      rem    <= rem_m1;
    end
  end
endmodule

// File: rtl/sseq_top.sv
`timescale 1ns/1ps
module sseq_top
  import sseq_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_en,
  input  logic [1:0]    cfg_dir,
  input  logic [1:0]    cfg_psize,
  input  logic [1:0]    cfg_msize,
  input  logic          cfg_pinc,
  input  logic          cfg_minc,
  input  logic          cfg_pfix,
  input  logic          cfg_pburst,
  input  logic          cfg_mburst,
  input  logic          cfg_circ,
  input  logic          cfg_dbuf,
  input  logic          cfg_pflow,
  input  logic [AW-1:0] cfg_paddr,
  input  logic [AW-1:0] cfg_m0addr,
  input  logic [AW-1:0] cfg_m1addr,
  input  logic [CW-1:0] cfg_count,
  input  logic          xfer_done,
  input  logic          periph_eot,
  output logic [AW-1:0] cur_paddr,
  output logic [AW-1:0] cur_maddr,
  output logic [CW-1:0] remaining,
  output logic          active,
  output logic          buf_sel,
  output logic          evt_half,
  output logic          evt_done,
  output logic          evt_err,
  output logic          irq
);
  localparam logic [STEP_W-1:0] FIX_STEP = 3'd4;

  logic en_q, active_q, half_q, done_q, err_q;
  logic start, bad, go, run, adv, last, half_hit, hit0, rewind, stop_cnt, eot_stop;
  logic [STEP_W-1:0] pstep, mstep;
  logic p_sel_unused;

  sseq_cfg_check u_check (
    .dir(cfg_dir), .psize(cfg_psize), .msize(cfg_msize),
    .pinc(cfg_pinc), .minc(cfg_minc), .pburst(cfg_pburst), .mburst(cfg_mburst),
    .circ(cfg_circ), .dbuf(cfg_dbuf),
    .p_lsb(cfg_paddr[1:0]), .m0_lsb(cfg_m0addr[1:0]), .m1_lsb(cfg_m1addr[1:0]),
    .count_zero(cfg_count == '0), .bad(bad)
  );

  always_comb begin
    start    = cfg_en & ~en_q & ~active_q;
    go       = start & ~bad;
    run      = active_q & cfg_en;
    adv      = run & xfer_done;
    hit0     = adv & last;
    rewind   = hit0 & (cfg_circ | cfg_dbuf);
    stop_cnt = hit0 & ~(cfg_circ | cfg_dbuf);
    eot_stop = run & cfg_pflow & periph_eot;
    if (!cfg_pinc)     pstep = '0;
    else if (cfg_pfix) pstep = FIX_STEP;
    else               pstep = wid_step(wid_e'(cfg_psize));
    mstep = cfg_minc ? wid_step(wid_e'(cfg_msize)) : '0;
  end

  sseq_ptr #(.AW(AW)) u_pptr (
    .clk(clk), .rst(rst), .load(go), .wrap(rewind), .swap(1'b0), .adv(adv),
    .step(pstep), .base0(cfg_paddr), .base1(cfg_paddr),
    .cur(cur_paddr), .sel(p_sel_unused)
  );

  sseq_ptr #(.AW(AW)) u_mptr (
    .clk(clk), .rst(rst), .load(go), .wrap(rewind), .swap(cfg_dbuf), .adv(adv),
    .step(mstep), .base0(cfg_m0addr), .base1(cfg_m1addr),
    .cur(cur_maddr), .sel(buf_sel)
  );

  sseq_count #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .load(go), .reload(rewind), .dec(adv),
    .prog(cfg_count), .rem(remaining), .last(last), .half_hit(half_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      active_q <= 1'b0;
      half_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      en_q <= cfg_en;
      if (start) begin
        active_q <= ~bad;
        half_q   <= 1'b0;
        done_q   <= 1'b0;
        err_q    <= bad;
      end else if (active_q) begin
        if (!cfg_en || stop_cnt || eot_stop) active_q <= 1'b0;
        if (adv && half_hit)                 half_q   <= 1'b1;
        if (hit0 || eot_stop)                done_q   <= 1'b1;
      end
    end
  end

  assign active   = active_q;
  assign evt_half = half_q;
  assign evt_done = done_q;
  assign evt_err  = err_q;
  assign irq      = half_q | done_q | err_q;
endmodule

// File: rtl/sseq_check.sv
`timescale 1ns/1ps
module sseq_check #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_en,
  input logic          cfg_pinc,
  input logic          cfg_pflow,
  input logic          xfer_done,
  input logic          periph_eot,
  input logic [AW-1:0] cur_paddr,
  input logic [CW-1:0] remaining,
  input logic          active,
  input logic          evt_done,
  input logic          evt_err
);
  AST_ACTIVE_NONZERO: assert property (@(posedge clk) disable iff (rst)
    active |-> remaining != '0); // R1
  AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    active && cfg_en && xfer_done && remaining > CW'(1) |=> remaining == $past(remaining) - CW'(1)); // R1
  AST_PTR_FIXED: assert property (@(posedge clk) disable iff (rst)
    active && cfg_en && xfer_done && !cfg_pinc && remaining > CW'(1) |=> $stable(cur_paddr)); // R2
  AST_DISABLE_STOP: assert property (@(posedge clk) disable iff (rst)
    active && !cfg_en |=> !active); // R5
  AST_EOT_STOP: assert property (@(posedge clk) disable iff (rst)
    active && cfg_en && cfg_pflow && periph_eot |=> !active && evt_done); // R6
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (rst)
    evt_err |-> !active); // R10
endmodule

bind sseq_top sseq_check #(.AW(AW), .CW(CW)) u_sseq_check (
  .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_pinc(cfg_pinc), .cfg_pflow(cfg_pflow),
  .xfer_done(xfer_done), .periph_eot(periph_eot), .cur_paddr(cur_paddr),
  .remaining(remaining), .active(active), .evt_done(evt_done), .evt_err(evt_err)
);

// File: tb/sseq_top_test.sv
`timescale 1ns/1ps
module sseq_top_test;
  localparam int AW = 32;
  localparam int CW = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, cfg_en, cfg_pinc, cfg_minc, cfg_pfix, cfg_pburst, cfg_mburst;
  logic cfg_circ, cfg_dbuf, cfg_pflow, xfer_done, periph_eot;
  logic [1:0] cfg_dir, cfg_psize, cfg_msize;
  logic [AW-1:0] cfg_paddr, cfg_m0addr, cfg_m1addr, cur_paddr, cur_maddr;
  logic [CW-1:0] cfg_count, remaining;
  logic active, buf_sel, evt_half, evt_done, evt_err, irq;

  sseq_top #(.AW(AW), .CW(CW)) uut (.*);

  int checks = 0;
  int errors = 0;
  bit m_en_q, m_act, m_buf, m_half, m_done, m_err;
  logic [31:0] m_p, m_m;
  logic [15:0] m_rem, m_prog;

  function automatic logic [31:0] f_step(input logic [1:0] w);
    return 32'd1 << w;
  endfunction

  function automatic bit f_al(input logic [1:0] w, input logic [31:0] a);
    return (a & (f_step(w) - 32'd1)) == 32'd0;
  endfunction

  function automatic bit f_bad();
    return cfg_psize == 2'd3 || cfg_msize == 2'd3 || cfg_dir == 2'd3 || cfg_count == 16'd0
        || !f_al(cfg_psize, cfg_paddr) || !f_al(cfg_msize, cfg_m0addr)
        || (cfg_dbuf && !f_al(cfg_msize, cfg_m1addr))
        || (cfg_pburst && !cfg_pinc) || (cfg_mburst && !cfg_minc)
        || (cfg_dir == 2'd2 && (cfg_circ || cfg_dbuf));
  endfunction

  function automatic logic [31:0] f_pstep();
    if (!cfg_pinc) return 32'd0;
    return cfg_pfix ? 32'd4 : f_step(cfg_psize);
  endfunction

  function automatic logic [31:0] f_mstep();
    return cfg_minc ? f_step(cfg_msize) : 32'd0;
  endfunction

  task automatic model_update();
    bit rise;
    rise = cfg_en && !m_en_q;
    m_en_q = cfg_en;
    if (!m_act) begin
      if (rise) begin
        m_half = 0; m_done = 0;
        if (f_bad()) m_err = 1;
        else begin
          m_err = 0; m_act = 1; m_buf = 0;
          m_p = cfg_paddr; m_m = cfg_m0addr; m_rem = cfg_count; m_prog = cfg_count;
        end
      end
    end else if (!cfg_en) begin
      m_act = 0;
    end else begin
      if (xfer_done) begin
        m_rem = m_rem - 16'd1;
        m_p = m_p + f_pstep();
        m_m = m_m + f_mstep();
        if (m_rem == (m_prog >> 1)) m_half = 1;
        if (m_rem == 16'd0) begin
          m_done = 1;
          if (cfg_circ || cfg_dbuf) begin
            m_rem = m_prog; m_p = cfg_paddr;
            if (cfg_dbuf) m_buf = !m_buf;
            m_m = m_buf ? cfg_m1addr : cfg_m0addr;
          end else m_act = 0;
        end
      end
      if (m_act && cfg_pflow && periph_eot) begin
        m_act = 0; m_done = 1;
      end
    end
  endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk(cur_paddr == m_p, "R2 R3 peripheral pointer", cur_paddr, m_p);
    chk(cur_maddr == m_m, "R2 R3 R8 memory pointer", cur_maddr, m_m);
    chk(remaining == m_rem, "R1 R7 remaining count", remaining, m_rem);
    chk(active == m_act, "R4 R5 R6 R10 active", active, m_act);
    chk(buf_sel == m_buf, "R8 buffer select", buf_sel, m_buf);
    chk(evt_half == m_half, "R9 half flag", evt_half, m_half);
    chk(evt_done == m_done, "R4 R6 R7 done flag", evt_done, m_done);
    chk(evt_err == m_err, "R10 error flag", evt_err, m_err);
    chk(irq == (m_half | m_done | m_err), "R11 irq", irq, m_half | m_done | m_err);
  endtask

  task automatic cyc(input bit xd, input bit eot);
    xfer_done = xd; periph_eot = eot;
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
  endtask

  task automatic setup(input logic [1:0] dir, input logic [1:0] ps, input logic [1:0] ms,
                       input bit pinc, input bit minc, input bit pfix, input bit circ,
                       input bit dbuf, input bit pflow, input bit pb, input bit mb,
                       input logic [31:0] pa, input logic [31:0] m0, input logic [31:0] m1,
                       input logic [15:0] cnt);
    cfg_dir = dir; cfg_psize = ps; cfg_msize = ms; cfg_pinc = pinc; cfg_minc = minc;
    cfg_pfix = pfix; cfg_circ = circ; cfg_dbuf = dbuf; cfg_pflow = pflow;
    cfg_pburst = pb; cfg_mburst = mb; cfg_paddr = pa; cfg_m0addr = m0; cfg_m1addr = m1;
    cfg_count = cnt;
    cfg_en = 0; cyc(0, 0);
    cfg_en = 1; cyc(0, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; cfg_en = 0; xfer_done = 0; periph_eot = 0;
    cfg_dir = 0; cfg_psize = 0; cfg_msize = 0; cfg_pinc = 0; cfg_minc = 0; cfg_pfix = 0;
    cfg_pburst = 0; cfg_mburst = 0; cfg_circ = 0; cfg_dbuf = 0; cfg_pflow = 0;
    cfg_paddr = 0; cfg_m0addr = 0; cfg_m1addr = 0; cfg_count = 0;
    m_en_q = 0; m_act = 0; m_buf = 0; m_half = 0; m_done = 0; m_err = 0;
    m_p = 0; m_m = 0; m_rem = 0; m_prog = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    compare(); // reset state, R1 R11

    // R1 R4 R9: single word item
    setup(2'd0, 2'd2, 2'd2, 1, 1, 0, 0, 0, 0, 0, 0, 32'h1000, 32'h2000, 32'h0, 16'd1);
    cyc(1, 0); cyc(0, 0);
    // R3: forced peripheral step with byte width, memory half-word step
    setup(2'd1, 2'd0, 2'd1, 1, 1, 1, 0, 0, 0, 1, 1, 32'h4001, 32'h8002, 32'h0, 16'd5);
    repeat (6) cyc(1, 0);
    // R8: two buffers, count 2, two full rounds
    setup(2'd0, 2'd1, 2'd2, 0, 1, 0, 0, 1, 0, 0, 0, 32'h40, 32'h100, 32'h200, 16'd2);
    repeat (5) cyc(1, 0);
    // R7 R6: circular with peripheral stop arriving together with the wrap transfer
    setup(2'd0, 2'd2, 2'd0, 1, 1, 0, 1, 0, 1, 0, 0, 32'h10, 32'h300, 32'h0, 16'd3);
    cyc(1, 0); cyc(1, 0); cyc(1, 1); cyc(1, 0);
    // R6: end signal ignored without peripheral flow control
    setup(2'd1, 2'd0, 2'd0, 1, 0, 0, 0, 0, 0, 0, 0, 32'h7, 32'h9, 32'h0, 16'd4);
    cyc(0, 1); cyc(1, 1);
    // R5: enable dropped mid-run, then restart
    cfg_en = 0; cyc(1, 0);
    cfg_en = 1; cyc(0, 0); cyc(1, 0);
    // R10: misaligned half-word, burst without increment, memory-to-memory circular, zero count
    setup(2'd0, 2'd1, 2'd0, 1, 1, 0, 0, 0, 0, 0, 0, 32'h3, 32'h0, 32'h0, 16'd4);
    setup(2'd0, 2'd0, 2'd0, 1, 0, 0, 0, 0, 0, 0, 1, 32'h3, 32'h0, 32'h0, 16'd4);
    setup(2'd2, 2'd0, 2'd0, 1, 1, 0, 1, 0, 0, 0, 0, 32'h3, 32'h0, 32'h0, 16'd4);
    setup(2'd0, 2'd0, 2'd0, 1, 1, 0, 0, 0, 0, 0, 0, 32'h3, 32'h0, 32'h0, 16'd0);
    cyc(1, 0);

    // random episodes
    for (int ep = 0; ep < 400; ep++) begin
      bit loose;
      loose = ($urandom_range(0, 9) == 0);
      cfg_dir = 2'($urandom_range(0, loose ? 3 : 2));
      cfg_psize = 2'($urandom_range(0, loose ? 3 : 2));
      cfg_msize = 2'($urandom_range(0, loose ? 3 : 2));
      cfg_pinc = 1'($urandom_range(0, 1)); cfg_minc = 1'($urandom_range(0, 1));
      cfg_pfix = 1'($urandom_range(0, 1)); cfg_pflow = 1'($urandom_range(0, 1));
      cfg_circ = ($urandom_range(0, 3) == 0); cfg_dbuf = ($urandom_range(0, 3) == 0);
      if (!loose && cfg_dir == 2'd2) begin cfg_circ = 0; cfg_dbuf = 0; end
      cfg_pburst = loose ? 1'($urandom_range(0, 1)) : (cfg_pinc & 1'($urandom_range(0, 1)));
      cfg_mburst = loose ? 1'($urandom_range(0, 1)) : (cfg_minc & 1'($urandom_range(0, 1)));
      cfg_paddr = $urandom; cfg_m0addr = $urandom; cfg_m1addr = $urandom;
      if (!loose) begin
        cfg_paddr  = cfg_paddr  & ~(f_step(cfg_psize) - 32'd1);
        cfg_m0addr = cfg_m0addr & ~(f_step(cfg_msize) - 32'd1);
        cfg_m1addr = cfg_m1addr & ~(f_step(cfg_msize) - 32'd1);
      end
      cfg_count = 16'($urandom_range(loose ? 0 : 1, ($urandom_range(0, 3) == 0) ? 40 : 9));
      cfg_en = 0; cyc(0, 0);
      cfg_en = 1;
      for (int k = 0; k < 60; k++) begin
        if ($urandom_range(0, 99) == 0) cfg_en = 0;
        cyc($urandom_range(0, 9) < 6, cfg_pflow ? ($urandom_range(0, 29) == 0) : ($urandom_range(0, 9) == 0));
        if (!m_act && k > 0) break;
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule